// File: doc/BRIEF.md
# Serial Sample Receiver with Split Dual-Code Output

This block receives audio samples sent one bit at a time and turns each sample into the pair of codes needed by a converter built from two complementary ladders. The sender provides a bit clock, a data line and a latch line. All three are brought into the system clock domain through synchronizers. On every rising bit-clock edge one data bit enters a shift register, most significant bit first. The sender may clock any number of bits. When the latch line falls, the 20 bits that arrived most recently are taken as one two's complement sample.

The sample is then split into two 19-bit straight-binary codes, one for the upper ladder and one for the lower ladder, plus a flag that adds one extra LSB of weight. A non-negative sample drives the upper code and parks the lower code at full scale with the flag set. A negative sample parks the upper code at zero and drives the lower code. Near zero, therefore, only the low-order bits of either code move, and the extra LSB keeps the transfer symmetric about zero. A one-cycle strobe marks each new pair of codes.

Top module: `sdac_rx`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the block resets to `upper_code` = 0, `lower_code` = all ones, `extra_lsb` = 1 and `upd_stb` = 0. This is the mapping for a zero sample.
- R2: Each rising edge of `ser_bclk` shifts the level of `ser_dat` into the sample. The first bit shifted becomes sample bit 19 (the sign bit) of a 20-bit word.
- R3: When more than 20 bits are shifted before the latch falls, only the last 20 form the sample. Earlier bits have no effect.
- R4: The codes change only on a falling edge of `ser_lat`. A rising edge of `ser_lat`, or a steady level, leaves the codes unchanged and raises no strobe.
- R5: When sample bit 19 is 0, `upper_code` equals sample bits 18..0, `lower_code` is all ones and `extra_lsb` is 1.
- R6: When sample bit 19 is 1, `upper_code` is 0, `lower_code` equals sample bits 18..0 and `extra_lsb` is 0.
- R7: Each falling edge of `ser_lat` raises `upd_stb` for exactly one `clk` cycle. The new codes first appear in that same cycle.
- R8: Bits shifted while no latch fall occurs (the start of the next word, or the bit clock stopped with the latch held low) leave the outputs unchanged until the next fall.
- R9: With the default depth of two synchronizer stages, a latch fall presented between two `clk` edges shows up at the outputs at the third rising `clk` edge after it. Before that edge the outputs still show the previous sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bclk | input | 1 | Serial bit clock (asynchronous to `clk`) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Latch line; its falling edge transfers the sample |
| upper_code | output | 19 | Straight-binary code for the upper ladder |
| lower_code | output | 19 | Straight-binary code for the lower ladder |
| extra_lsb | output | 1 | Adds one LSB of weight on the non-negative side |
| upd_stb | output | 1 | One-cycle pulse when new codes appear |

## Verification
The hardest case to reach from the ports is a word whose bits are not all its own. Bits shifted before the word must be dropped. Bits shifted after a transfer, with no new latch fall, must leave the outputs alone. The bench therefore sends a word preceded by seven bits of the opposite pattern and checks that only the last twenty count. It then clocks a whole new word with the latch held low, and separately toggles the latch high and back up without a fall. After each of these it reads the codes and the strobe to confirm that nothing moved. Every transfer is also checked at an exact `clk` edge, one edge too early and then on time, to pin the latency.

// File: rtl/sdac_pkg.sv
// Package: shared constants for the serial sample receiver.
// Assumes: the sample width is at least 2 bits (a sign bit plus a code).
package sdac_pkg;
    localparam int unsigned SAMPLE_W_DEF = 20;
    localparam int unsigned SYNC_DEF     = 2;
    // Lane positions inside the synchronizer bundle.
    localparam int unsigned LANE_BCLK = 0;
    localparam int unsigned LANE_DAT  = 1;
    localparam int unsigned LANE_LAT  = 2;
    localparam int unsigned NUM_LANES = 3;
endpackage

// File: rtl/sdac_sync.sv
// Module: multi-bit, multi-stage synchronizer chain.
// Does: passes each input lane through STAGES flops clocked by clk.
// Assumes: lanes are slow compared with clk; skew between lanes is absorbed
// because the sender holds data stable for several clk cycles around edges.
module sdac_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous lanes.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= din;
            end
        end else begin : g_next
            // Later stages let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
// Module: edge finder for the synchronized bit clock and latch line.
// Does: flags a rising bit-clock edge and a falling latch edge, one cycle each.
// Assumes: inputs are already synchronized to clk. History resets to 0, so a
// latch line idling high after reset does not produce a false fall.
module sdac_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic s_bclk,
    input  logic s_lat,
    output logic bclk_rise,
    output logic lat_fall
);
    logic bclk_q;
    logic lat_q;

    // Keep last cycle's levels to compare against.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            bclk_q <= s_bclk;
            lat_q  <= s_lat;
        end
    end

    assign bclk_rise = s_bclk & ~bclk_q;
    assign lat_fall  = lat_q & ~s_lat;
endmodule

// File: rtl/sdac_shift.sv
// Module: serial-in shift register holding the most recent SAMPLE_W bits.
// Does: on each shift enable, moves the word up one place and enters the new
// bit at bit 0, so the first bit sent ends up as the MSB and older bits fall off.
// Assumes: shift_en is a single-cycle pulse per bit.
module sdac_shift #(
    parameter int unsigned SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                bit_in,
    output logic [SAMPLE_W-1:0] word
);
    // Shift one bit in, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[SAMPLE_W-2:0], bit_in};
    end
endmodule

// File: rtl/sdac_split.sv
// Module: two's complement to complementary dual-code mapper with output registers.
// Does: on load, registers the upper/lower codes and the extra-LSB flag, and
// pulses the update strobe for the same cycle.
// Assumes: load is a single-cycle pulse. The reset state is the zero mapping.
module sdac_split #(
    parameter int unsigned SAMPLE_W = 20,
    localparam int unsigned CODE_W  = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [CODE_W-1:0]   upper_code,
    output logic [CODE_W-1:0]   lower_code,
    output logic                extra_lsb,
    output logic                upd_stb
);
    logic              neg;
    logic [CODE_W-1:0] mag;
    logic [CODE_W-1:0] up_nx;
    logic [CODE_W-1:0] lo_nx;

    assign neg = sample[SAMPLE_W-1];
    assign mag = sample[CODE_W-1:0];

    // Choose which ladder moves: the upper one for non-negative samples, the lower one otherwise.
    always_comb begin
        if (neg) begin
            up_nx = '0;
            lo_nx = mag;
        end else begin
            up_nx = mag;
            lo_nx = '1;
        end
    end

    // Register codes on load and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_code <= '0;
            lower_code <= '1;
            extra_lsb  <= 1'b1;
            upd_stb    <= 1'b0;
        end else begin
            upd_stb <= load;
            if (load) begin
                upper_code <= up_nx;
                lower_code <= lo_nx;
                extra_lsb  <= ~neg;
            end
        end
    end
endmodule

// File: rtl/sdac_rx.sv
// Module: serial sample receiver with split dual-code output (top).
// Does: synchronizes the bit clock, data and latch lines; shifts bits on bit-clock
// rises; on a latch fall maps the last SAMPLE_W bits to upper/lower codes.
// Assumes: the bit clock and latch line each stay at a level for at least
// SYNC_STAGES+1 clk cycles, and data is stable around each bit-clock rise.
// If a bit-clock rise and a latch fall are seen in the same cycle, the sample
// is taken before that bit enters.
module sdac_rx #(
    parameter int unsigned SAMPLE_W    = sdac_pkg::SAMPLE_W_DEF,
    parameter int unsigned SYNC_STAGES = sdac_pkg::SYNC_DEF,
    localparam int unsigned CODE_W     = SAMPLE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bclk,
    input  logic              ser_dat,
    input  logic              ser_lat,
    output logic [CODE_W-1:0] upper_code,
    output logic [CODE_W-1:0] lower_code,
    output logic              extra_lsb,
    output logic              upd_stb
);
    import sdac_pkg::*;

    logic [NUM_LANES-1:0] raw_lanes;
    logic [NUM_LANES-1:0] syn_lanes;
    logic                 bclk_rise;
    logic                 lat_fall;
    logic [SAMPLE_W-1:0]  shift_word;

    // Gather the asynchronous lanes into one bundle.
    always_comb begin
        raw_lanes            = '0;
        raw_lanes[LANE_BCLK] = ser_bclk;
        raw_lanes[LANE_DAT]  = ser_dat;
        raw_lanes[LANE_LAT]  = ser_lat;
    end

    sdac_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lanes),
        .dout  (syn_lanes)
    );

    sdac_edge edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_bclk    (syn_lanes[LANE_BCLK]),
        .s_lat     (syn_lanes[LANE_LAT]),
        .bclk_rise (bclk_rise),
        .lat_fall  (lat_fall)
    );

    sdac_shift #(.SAMPLE_W(SAMPLE_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bclk_rise),
        .bit_in   (syn_lanes[LANE_DAT]),
        .word     (shift_word)
    );

    sdac_split #(.SAMPLE_W(SAMPLE_W)) split_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (lat_fall),
        .sample     (shift_word),
        .upper_code (upper_code),
        .lower_code (lower_code),
        .extra_lsb  (extra_lsb),
        .upd_stb    (upd_stb)
    );
endmodule

// File: rtl/sdac_rx_chk.sv
// Checker: temporal properties of the serial sample receiver outputs.
// Assumes: bound to sdac_rx; observes ports only.
module sdac_rx_chk #(
    parameter int unsigned CODE_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] upper_code,
    input logic [CODE_W-1:0] lower_code,
    input logic              extra_lsb,
    input logic              upd_stb
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (upper_code == '0 && lower_code == '1 && extra_lsb && !upd_stb)); // R1

    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |-> ($stable(upper_code) && $stable(lower_code) && $stable(extra_lsb))); // R4

    AST_POS_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        extra_lsb |-> lower_code == '1); // R5

    AST_NEG_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !extra_lsb |-> upper_code == '0); // R6

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb); // R7
endmodule

bind sdac_rx sdac_rx_chk #(.CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .upper_code (upper_code),
    .lower_code (lower_code),
    .extra_lsb  (extra_lsb),
    .upd_stb    (upd_stb)
);

// File: tb/sdac_rx_tb_top.sv
// Bench: directed tests for sdac_rx; each task checks its own results.
module sdac_rx_tb_top;
    localparam int W  = 20;
    localparam int CW = W - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_bclk = 1'b0;
    logic          ser_dat = 1'b0;
    logic          ser_lat = 1'b0;
    logic [CW-1:0] upper_code;
    logic [CW-1:0] lower_code;
    logic          extra_lsb;
    logic          upd_stb;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdac_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ser_bclk(ser_bclk), .ser_dat(ser_dat),
        .ser_lat(ser_lat), .upper_code(upper_code), .lower_code(lower_code),
        .extra_lsb(extra_lsb), .upd_stb(upd_stb)
    );

    // Count strobe pulses.
    always @(posedge clk) if (rst_n && upd_stb) stb_cnt <= stb_cnt + 1;

    // Expected mapping, computed from R5/R6.
    function automatic logic [2*CW:0] model(input logic [W-1:0] s);
        if (s[W-1]) return {{CW{1'b0}}, s[CW-1:0], 1'b0};
        else        return {s[CW-1:0], {CW{1'b1}}, 1'b1};
    endfunction

    task automatic check_out(input string req, input logic [2*CW:0] exp);
        n_chk++;
        if ({upper_code, lower_code, extra_lsb} !== exp) begin
            n_bad++;
            $display("FAIL %s: got up=%h lo=%h f=%b expected up=%h lo=%h f=%b", req,
                     upper_code, lower_code, extra_lsb,
                     exp[2*CW:CW+1], exp[CW:1], exp[0]);
        end
    endtask

    task automatic check_val(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Send nbits of val, MSB first; each bit level is held several clk cycles.
    task automatic send_bits(input logic [31:0] val, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk) ser_dat = val[i];
            repeat (4) @(negedge clk);
            ser_bclk = 1'b1;
            repeat (5) @(negedge clk);
            ser_bclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // Raise then drop the latch; check exact latency (R9), strobe (R7) and codes.
    task automatic latch_and_check(input string req, input logic [2*CW:0] prev,
                                   input logic [2*CW:0] exp);
        int base;
        @(negedge clk) ser_lat = 1'b1;
        repeat (6) @(negedge clk);
        base = stb_cnt;
        ser_lat = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_out({req, " R9 not before third edge"}, prev);
        check_val("R9 strobe early", int'(upd_stb), 0);
        @(negedge clk);
        check_out(req, exp);
        check_val("R7 strobe with codes", int'(upd_stb), 1);
        @(negedge clk);
        check_val("R7 strobe one cycle", int'(upd_stb), 0);
        check_val("R7 one pulse per fall", stb_cnt - base, 1);
        repeat (3) @(negedge clk);
    endtask

    logic [2*CW:0] cur;

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check_out("R1 reset codes", model(20'h00000));
        check_val("R1 reset strobe", int'(upd_stb), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cur = model(20'h00000);
    endtask

    task automatic t_word(input string req, input logic [W-1:0] s);
        send_bits({12'h0, s}, W);
        latch_and_check(req, cur, model(s));
        cur = model(s);
    endtask

    task automatic t_prefix();
        send_bits(32'h0000007F, 7);                // junk ones ahead of word
        send_bits({12'h0, 20'h00A5C}, W);
        latch_and_check("R3 extra leading bits dropped", cur, model(20'h00A5C));
        cur = model(20'h00A5C);
    endtask

    task automatic t_no_update();
        int base;
        base = stb_cnt;
        send_bits({12'h0, 20'hC0001}, W);          // latch held low throughout
        repeat (6) @(negedge clk);
        check_out("R8 shifted bits without fall", cur);
        ser_lat = 1'b1;                            // rise only
        repeat (10) @(negedge clk);
        check_out("R4 latch rise no change", cur);
        check_val("R4 no strobe on rise", stb_cnt - base, 0);
        latch_and_check("R8 stopped-clock word on next fall", cur, model(20'hC0001));
        cur = model(20'hC0001);
    endtask

    initial begin
        t_reset();
        t_word("R2 R5 positive word", 20'h12345);
        t_word("R6 all ones negative", 20'hFFFFF);
        t_word("R5 zero word", 20'h00000);
        t_word("R6 most negative", 20'h80000);
        t_word("R5 most positive", 20'h7FFFF);
        t_word("R2 alternating pattern", 20'hAAAAA);
        t_prefix();
        t_no_update();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule